// File: doc/BRIEF.md
# Chunked External-to-Local Copy Engine

This block copies data from an external memory space into one of three local memories of an embedded controller, one fixed 256-byte chunk per command. Software programs a 256-byte-granular external base address split over two registers, a byte offset added to that base, and a byte offset into the chosen local memory. It then writes a command word that names the chunk size and the destination. While a chunk is moving, the engine reports busy by holding its idle output low. Software polls that output before it issues the next command. Software repeats the sequence once for each chunk it needs.

External reads go out as 32-bit word requests on a valid/ready request channel. A request stays valid, with its address unchanged, until ready is seen, and more than one request may be outstanding. Read data comes back in request order on a valid/ready response channel. The engine holds the response ready only while a chunk is in progress. Each accepted response word is written in the same cycle into the selected local memory at consecutive word addresses. The local write port has no back-pressure. A command that arrives while the engine is busy is dropped and raises a sticky error flag. So does a command with a size code or destination code that the engine does not accept. Writing zero to the control register clears the flag and the programmed address registers.

Top module: `chunk_dma`

## Requirements
- R1: After reset, idle_o is 1, err_o is 0, rd_req_valid is 0, rd_rsp_ready is 0 and mem_we is 0.
- R2: A write to register 4 (command) with size field [2:0] = 6 and destination field [5:4] in 0..2, issued while idle, drives idle_o low from the next cycle. idle_o returns high in the cycle after the 64th response word is accepted.
- R3: Each chunk issues exactly 64 requests. Request k (k = 0..63) carries the 49-bit address ({hi,lo} shifted left by 8) + ext + 4k, modulo 2^49. Here lo is register 0 (32 bits), hi is register 1 (bits [8:0]) and ext is register 3 (32 bits). A request held without ready keeps valid high and its address stable.
- R4: The i-th accepted response word (i = 0..63) is written with mem_we = 1 at mem_addr = loc + 4i, modulo 2^16, where loc is register 2 (bits [15:0]). mem_wdata equals the response data and mem_sel equals the destination code (0 secure instruction, 1 non-secure instruction, 2 data).
- R5: rd_rsp_ready is 1 exactly while a chunk is in progress, and no local write occurs while idle.
- R6: A command write while busy is ignored (the current chunk continues unchanged) and sets err_o from the next cycle.
- R7: A command whose size field is not 6 sets err_o and leaves the engine idle.
- R8: A command with destination code 3 sets err_o and leaves the engine idle.
- R9: Writing zero to register 5 (control) clears err_o and resets registers 0 to 3 to zero. A nonzero write to it has no effect.
- R10: Register writes made during a chunk do not change that chunk's request or write addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Register write data |
| idle_o | output | 1 | High when no chunk is in progress |
| err_o | output | 1 | Sticky command error flag |
| rd_req_valid | output | 1 | External read request valid |
| rd_req_ready | input | 1 | External read request ready |
| rd_req_addr | output | 49 | External byte address of the requested word |
| rd_rsp_valid | input | 1 | External read data valid |
| rd_rsp_ready | output | 1 | Engine accepts read data |
| rd_rsp_data | input | 32 | External read data word |
| mem_we | output | 1 | Local memory write enable |
| mem_sel | output | 2 | Destination memory select |
| mem_addr | output | 16 | Local byte address of the written word |
| mem_wdata | output | 32 | Local write data |

## Verification
Request-ready and response-valid are throttled pseudo-randomly, so requests run ahead of responses and stall. A design that moved its address during a stall, or that counted requests and responses with one counter, would issue a wrong or skipped address, or finish early. Addresses are chosen to carry across the 40-bit base boundary and to wrap at 49 bits and at 16 bits; a design that split the base wrongly would read the wrong location. A command and a register write are issued in the middle of a chunk. A design that accepted the command or failed to latch its offsets would redirect the transfer and leave the error flag clear. Bad size and destination codes, and the two kinds of control write, show whether an engine starts a transfer it should refuse or misses its clear.

// File: rtl/dmx_pkg.sv
package dmx_pkg;
  localparam int REG_AW = 3;
  localparam logic [REG_AW-1:0] RA_BASE_LO = 3'd0;
  localparam logic [REG_AW-1:0] RA_BASE_HI = 3'd1;
  localparam logic [REG_AW-1:0] RA_LOC     = 3'd2;
  localparam logic [REG_AW-1:0] RA_EXT     = 3'd3;
  localparam logic [REG_AW-1:0] RA_CMD     = 3'd4;
  localparam logic [REG_AW-1:0] RA_CTRL    = 3'd5;
  localparam logic [2:0] SIZE_256 = 3'd6;
  localparam int BASE_SH = 8;
  localparam int HI_SH   = 40;

  typedef enum logic [1:0] {
    DST_IMEM_SEC = 2'd0,
    DST_IMEM_NS  = 2'd1,
    DST_DMEM     = 2'd2,
    DST_BAD      = 2'd3
  } dest_e;
endpackage

// File: rtl/dmx_regs.sv
module dmx_regs
  import dmx_pkg::*;
#(
  parameter int EXT_AW = 49,
  parameter int LOC_AW = 16,
  parameter int OFS_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  input  logic              busy,
  output logic [EXT_AW-1:0] base_addr,
  output logic [OFS_W-1:0]  ext_ofs,
  output logic [LOC_AW-1:0] loc_ofs,
  output logic              start,
  output dest_e             start_dest,
  output logic              err
);
  localparam int HI_W = EXT_AW - HI_SH;

  logic [31:0]     base_lo;
  logic [HI_W-1:0] base_hi;
  logic cmd_wr, size_ok, dest_ok, ctrl_clr;

  assign cmd_wr     = reg_we && (reg_addr == RA_CMD);
  assign size_ok    = (reg_wdata[2:0] == SIZE_256);
  assign dest_ok    = (reg_wdata[5:4] != DST_BAD);
  assign start      = cmd_wr && !busy && size_ok && dest_ok;
  assign start_dest = dest_e'(reg_wdata[5:4]);
  assign ctrl_clr   = reg_we && (reg_addr == RA_CTRL) && (reg_wdata == 32'd0);
  assign base_addr  = {base_hi, base_lo, {BASE_SH{1'b0}}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo <= '0;
      base_hi <= '0;
      loc_ofs <= '0;
      ext_ofs <= '0;
      err     <= 1'b0;
    end else if (ctrl_clr) begin
      base_lo <= '0;
      base_hi <= '0;
      loc_ofs <= '0;
      ext_ofs <= '0;
      err     <= 1'b0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_BASE_LO: base_lo <= reg_wdata;
        RA_BASE_HI: base_hi <= reg_wdata[HI_W-1:0];
        RA_LOC:     loc_ofs <= reg_wdata[LOC_AW-1:0];
        RA_EXT:     ext_ofs <= reg_wdata[OFS_W-1:0];
        RA_CMD:     if (!start) err <= 1'b1;
        default: ;
      endcase
    end
  end

  // R6
  busy_cmd_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr && busy |=> err);

  // R9
  ctrl_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_clr |=> !err && base_addr == '0);
endmodule

// File: rtl/dmx_reqgen.sv
module dmx_reqgen #(
  parameter int EXT_AW = 49,
  parameter int OFS_W  = 32,
  parameter int WORDS  = 64,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [EXT_AW-1:0] base_addr,
  input  logic [OFS_W-1:0]  ext_ofs,
  input  logic              rd_req_ready,
  output logic              rd_req_valid,
  output logic [EXT_AW-1:0] rd_req_addr
);
  localparam int CNT_W   = $clog2(WORDS + 1);
  localparam int STEP_SH = $clog2(DW / 8);

  logic [EXT_AW-1:0] first;
  logic [CNT_W-1:0]  cnt;
  logic              active;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first  <= '0;
      cnt    <= '0;
      active <= 1'b0;
    end else if (start) begin
      first  <= base_addr + EXT_AW'(ext_ofs);
      cnt    <= '0;
      active <= 1'b1;
    end else if (active && rd_req_ready) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(WORDS - 1)) active <= 1'b0;
    end
  end

  assign rd_req_valid = active;
  assign rd_req_addr  = first + (EXT_AW'(cnt) << STEP_SH);

  // R3
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
endmodule

// File: rtl/dmx_wrseq.sv
module dmx_wrseq
  import dmx_pkg::*;
#(
  parameter int LOC_AW = 16,
  parameter int WORDS  = 64,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  dest_e             start_dest,
  input  logic [LOC_AW-1:0] loc_ofs,
  input  logic              rd_rsp_valid,
  input  logic [DW-1:0]     rd_rsp_data,
  output logic              rd_rsp_ready,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  output logic [LOC_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata,
  output logic              busy
);
  localparam int CNT_W   = $clog2(WORDS + 1);
  localparam int STEP_SH = $clog2(DW / 8);

  logic [CNT_W-1:0]  cnt;
  logic [LOC_AW-1:0] loc_base;
  dest_e             dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      cnt      <= '0;
      loc_base <= '0;
      dest     <= DST_IMEM_SEC;
    end else if (start) begin
      busy     <= 1'b1;
      cnt      <= '0;
      loc_base <= loc_ofs;
      dest     <= start_dest;
    end else if (mem_we) begin
      cnt <= cnt + 1'b1;
      if (cnt == CNT_W'(WORDS - 1)) busy <= 1'b0;
    end
  end

  assign rd_rsp_ready = busy;
  assign mem_we       = busy && rd_rsp_valid;
  assign mem_sel      = dest;
  assign mem_addr     = loc_base + (LOC_AW'(cnt) << STEP_SH);
  assign mem_wdata    = rd_rsp_data;

  // R4
  wr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we && busy && !start |=> !busy || mem_addr == $past(mem_addr) + LOC_AW'(DW / 8));
endmodule

// File: rtl/chunk_dma.sv
module chunk_dma
  import dmx_pkg::*;
#(
  parameter int EXT_AW = 49,
  parameter int LOC_AW = 16,
  parameter int OFS_W  = 32,
  parameter int WORDS  = 64,
  parameter int DW     = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              idle_o,
  output logic              err_o,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [EXT_AW-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  output logic              rd_rsp_ready,
  input  logic [DW-1:0]     rd_rsp_data,
  output logic              mem_we,
  output logic [1:0]        mem_sel,
  output logic [LOC_AW-1:0] mem_addr,
  output logic [DW-1:0]     mem_wdata
);
  logic              busy, start;
  dest_e             start_dest;
  logic [EXT_AW-1:0] base_addr;
  logic [OFS_W-1:0]  ext_ofs;
  logic [LOC_AW-1:0] loc_ofs;

  dmx_regs #(.EXT_AW(EXT_AW), .LOC_AW(LOC_AW), .OFS_W(OFS_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .busy(busy), .base_addr(base_addr),
    .ext_ofs(ext_ofs), .loc_ofs(loc_ofs), .start(start),
    .start_dest(start_dest), .err(err_o)
  );

  dmx_reqgen #(.EXT_AW(EXT_AW), .OFS_W(OFS_W), .WORDS(WORDS), .DW(DW)) u_req (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .ext_ofs(ext_ofs), .rd_req_ready(rd_req_ready),
    .rd_req_valid(rd_req_valid), .rd_req_addr(rd_req_addr)
  );

  dmx_wrseq #(.LOC_AW(LOC_AW), .WORDS(WORDS), .DW(DW)) u_wr (
    .clk(clk), .rst_n(rst_n), .start(start), .start_dest(start_dest),
    .loc_ofs(loc_ofs), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .rd_rsp_ready(rd_rsp_ready), .mem_we(mem_we), .mem_sel(mem_sel),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy)
  );

  assign idle_o = !busy;

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !idle_o && rd_req_valid);

  // R2
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid |-> !idle_o);

  // R5
  no_idle_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idle_o |-> !mem_we && !rd_rsp_ready);
endmodule

// File: tb/chunk_dma_tb.sv
module chunk_dma_tb;
  localparam int CLK_PERIOD = 10;
  localparam longint unsigned AMASK = (64'd1 << 49) - 1;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic        idle_o, err_o, rd_req_valid, rd_rsp_ready, mem_we;
  logic        rd_req_ready = 1'b0;
  logic        rd_rsp_valid = 1'b0;
  logic [31:0] rd_rsp_data = '0;
  logic [48:0] rd_req_addr;
  logic [1:0]  mem_sel;
  logic [15:0] mem_addr;
  logic [31:0] mem_wdata;

  chunk_dma u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .idle_o(idle_o), .err_o(err_o),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
    .rd_req_addr(rd_req_addr), .rd_rsp_valid(rd_rsp_valid),
    .rd_rsp_ready(rd_rsp_ready), .rd_rsp_data(rd_rsp_data),
    .mem_we(mem_we), .mem_sel(mem_sel), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int wr_seen = 0;
  logic [15:0] lfsr = 16'hACE1;
  longint unsigned rq[$];

  // reference model state
  bit              m_busy, m_err;
  int              m_reqn, m_rspn;
  longint unsigned m_first, m_lo, m_hi, m_ext, m_loc, m_cloc;
  int              m_dest;

  task automatic chk(string tag, longint unsigned act, longint unsigned exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic longint unsigned rsp_word(longint unsigned a);
    return (a ^ (a >> 17) ^ 64'hC3A5_0F1E) & 64'hFFFF_FFFF;
  endfunction

  // response/ready driver
  always @(negedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    rd_req_ready <= lfsr[0] | lfsr[3];
    if (rq.size() > 0 && (lfsr[5] | lfsr[7])) begin
      rd_rsp_valid <= 1'b1;
      rd_rsp_data  <= rq[0][31:0];
    end else begin
      rd_rsp_valid <= 1'b0;
      rd_rsp_data  <= '0;
    end
  end

  // compare against the model, then advance it by one clock
  always @(negedge clk) begin
    #2;
    if (!rst_n) begin
      m_busy = 0; m_err = 0; m_reqn = 0; m_rspn = 0;
      m_first = 0; m_lo = 0; m_hi = 0; m_ext = 0; m_loc = 0; m_cloc = 0; m_dest = 0;
    end else begin
      bit e_rv, e_we;
      longint unsigned e_ra;
      e_rv = m_busy && m_reqn < 64;
      e_ra = (m_first + 4 * longint'(m_reqn)) & AMASK;
      e_we = m_busy && rd_rsp_valid;
      chk("R2 idle", idle_o, !m_busy);
      chk("R6 R7 R8 R9 err", err_o, m_err);
      chk("R3 req_valid", rd_req_valid, e_rv);
      if (e_rv) chk("R3 R10 req_addr", rd_req_addr, e_ra);
      chk("R5 rsp_ready", rd_rsp_ready, m_busy);
      chk("R4 R5 mem_we", mem_we, e_we);
      if (e_we) begin
        chk("R4 R10 mem_addr", mem_addr, (m_cloc + 4 * longint'(m_rspn)) & 16'hFFFF);
        chk("R4 mem_sel", mem_sel, m_dest);
        chk("R4 mem_wdata", mem_wdata, rq[0]);
        wr_seen++;
      end
      // advance
      if (e_rv && rd_req_ready) begin
        rq.push_back(rsp_word(e_ra));
        m_reqn++;
      end
      if (e_we) begin
        void'(rq.pop_front());
        m_rspn++;
        if (m_rspn == 64) m_busy = 0;
      end
      if (reg_we) begin
        case (reg_addr)
          3'd0: m_lo = reg_wdata;
          3'd1: m_hi = reg_wdata[8:0];
          3'd2: m_loc = reg_wdata[15:0];
          3'd3: m_ext = reg_wdata;
          3'd4: begin
            if (!(m_busy || (e_we && m_rspn == 64)) && reg_wdata[2:0] == 3'd6 && reg_wdata[5:4] != 2'd3) begin
              m_busy = 1; m_reqn = 0; m_rspn = 0;
              m_first = (((m_hi << 40) | (m_lo << 8)) + m_ext) & AMASK;
              m_cloc = m_loc; m_dest = reg_wdata[5:4];
            end else m_err = 1;
          end
          3'd5: if (reg_wdata == 0) begin
            m_err = 0; m_lo = 0; m_hi = 0; m_loc = 0; m_ext = 0;
          end
          default: ;
        endcase
      end
    end
  end

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
  endtask

  task automatic run_chunk(input logic [31:0] cmd);
    wr_seen = 0;
    wr(3'd4, cmd);
    while (!idle_o) @(negedge clk);
    chk("R2 R4 words written", wr_seen, 64);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 idle", idle_o, 1);
    chk("R1 err", err_o, 0);
    chk("R1 req_valid", rd_req_valid, 0);
    chk("R1 rsp_ready", rd_rsp_ready, 0);
    chk("R1 mem_we", mem_we, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // chunk 1: secure instruction memory, busy command and offset rewrite mid-flight
    wr(3'd0, 32'h89AB_CDEF);
    wr(3'd1, 32'h0000_01AB);
    wr(3'd2, 32'h0000_0200);
    wr(3'd3, 32'h0000_0100);
    wr_seen = 0;
    wr(3'd4, 32'h0000_0006);
    chk("R2 busy after command", idle_o, 0);
    wr(3'd4, 32'h0000_0016);
    chk("R6 err after busy command", err_o, 1);
    wr(3'd3, 32'h0000_7777);
    wr(3'd2, 32'h0000_4444);
    while (!idle_o) @(negedge clk);
    chk("R6 R10 words written", wr_seen, 64);

    // R9 nonzero control write leaves err set, zero write clears
    wr(3'd5, 32'h0000_0005);
    chk("R9 nonzero ctrl", err_o, 1);
    wr(3'd5, 32'h0000_0000);
    chk("R9 zero ctrl clears err", err_o, 0);

    // chunk 2: data memory, wrap at 49 and 16 bits
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd1, 32'h0000_01FF);
    wr(3'd3, 32'hFFFF_FF00);
    wr(3'd2, 32'h0000_FF80);
    run_chunk(32'h0000_0026);

    // chunk 3: non-secure instruction memory
    wr(3'd0, 32'h0001_2345);
    wr(3'd1, 32'h0000_0000);
    wr(3'd3, 32'h0000_0040);
    wr(3'd2, 32'h0000_1000);
    run_chunk(32'h0000_0016);
    chk("R2 err clear after good chunks", err_o, 0);

    // R7 bad size
    wr(3'd4, 32'h0000_0017);
    chk("R7 err", err_o, 1);
    chk("R7 stays idle", idle_o, 1);
    repeat (3) @(negedge clk);
    chk("R7 no request", rd_req_valid, 0);
    wr(3'd5, 32'h0);

    // R8 bad destination
    wr(3'd4, 32'h0000_0036);
    chk("R8 err", err_o, 1);
    chk("R8 stays idle", idle_o, 1);
    repeat (3) @(negedge clk);
    chk("R8 no request", rd_req_valid, 0);

    // R9 cleared registers: chunk from address zero into local zero
    wr(3'd5, 32'h0);
    chk("R9 err cleared", err_o, 0);
    run_chunk(32'h0000_0016);

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule